// File: doc/BRIEF.md
# Binary Early/Late Phase Detector

This block is the digital phase detector of a clock and data recovery loop. It runs on the recovered bit clock. It samples the serial line twice in every bit period. The rising edge takes the sample at the centre of the bit. The falling edge takes the sample at the boundary between that bit and the next one.

When two consecutive centre samples differ, the line has a transition. The boundary sample between those two bits then shows on which side of the data edge the clock sits. The block turns that into a one-period raise or lower command for a charge pump. With no transition there is nothing to measure, so the command stays idle (the tristate case).

A mode input from the lock detector enables the detector. While the loop is in acquisition mode, the outputs are forced idle. The centre samples are also delivered as retimed serial data.

Top module: `bbpd_top`

## Requirements
- R1: `rdata_o` presents the centre sample taken at a rising edge of `clk` during the period after the next rising edge, so the retimed data lags the line by one clock period.
- R2: When the two most recent centre samples are equal, `up_o` and `dn_o` are both 0 in the following period.
- R3: When the centre samples differ and the boundary sample between them equals the older centre sample, `up_o` is 1 and `dn_o` is 0 in the following period.
- R4: When the centre samples differ and the boundary sample between them equals the newer centre sample, `dn_o` is 1 and `up_o` is 0 in the following period.
- R5: `up_o` and `dn_o` are never 1 at the same time.
- R6: Each command is registered and lasts exactly one clock period. It appears on the rising edge that follows the centre sample of the newer bit.
- R7: When `cdr_mode_i` is 0 at the rising edge that registers a command, both `up_o` and `dn_o` are 0 for that period, whatever the line does. The retimed data is not affected by the mode.
- R8: While `rst` is 1 at rising edges, all sample registers clear. `up_o`, `dn_o` and `rdata_o` read 0 from the edge after reset is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock; rising edge samples the bit centre, falling edge the bit boundary |
| rst | input | 1 | Synchronous active-high reset |
| sdata_i | input | 1 | Serial line input |
| cdr_mode_i | input | 1 | 1 = data-tracking mode (detector drives the loop), 0 = acquisition (outputs idle) |
| up_o | output | 1 | Raise request to the charge pump (source current) |
| dn_o | output | 1 | Lower request to the charge pump (sink current) |
| rdata_o | output | 1 | Retimed serial data (centre samples) |

## Verification
The block has no parameters, so the bench builds it as it is. The bench moves each data transition either 3 ns before or 3 ns after the falling edge of the 20 ns clock. This produces both orders of the boundary sample against the centre samples, so it exercises both the raise and the lower decisions. Long runs of equal bits test the hold case. A pseudo-random bit stream with a random offset per bit mixes all three decisions in consecutive periods. A stretch in acquisition mode, and a reset in the middle of traffic, test that the commands are gated while the retimed data keeps flowing.

// File: rtl/bbpd_pkg.sv
package bbpd_pkg;

    // Charge pump command carried from the decision to the output stage
    typedef enum logic [1:0] {
        PD_HOLD  = 2'b00,
        PD_RAISE = 2'b01,
        PD_LOWER = 2'b10
    } pd_cmd_e;

    // Three samples that frame one possible data transition
    typedef struct packed {
        logic older;  // centre sample of the earlier bit
        logic bnd;    // boundary sample between the two bits
        logic newer;  // centre sample of the later bit
    } bit_window_t;

    localparam bit_window_t WINDOW_CLEAR = '{older: 1'b0, bnd: 1'b0, newer: 1'b0};

    function automatic logic has_transition(bit_window_t w);
        return w.older != w.newer;
    endfunction

    function automatic pd_cmd_e pd_decide(bit_window_t w);
        pd_cmd_e c;
        if (!has_transition(w))
            c = PD_HOLD;
        else if (w.bnd == w.older)
            c = PD_RAISE;
        else
            c = PD_LOWER;
        return c;
    endfunction

endpackage

// File: rtl/bbpd_sampler.sv
module bbpd_sampler
    import bbpd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sdata_i,
    output bit_window_t win_o,
    output logic        rdata_o
);

    logic bnd_fall;   // captured on the falling edge
    logic bnd_q;      // boundary sample moved into the rising-edge domain
    logic ctr_q;      // newest centre sample
    logic ctr_d1;     // previous centre sample

    always_ff @(negedge clk) begin
        if (rst) bnd_fall <= 1'b0;
        else     bnd_fall <= sdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bnd_q  <= 1'b0;
            ctr_q  <= 1'b0;
            ctr_d1 <= 1'b0;
        end else begin
            bnd_q  <= bnd_fall;
            ctr_q  <= sdata_i;
            ctr_d1 <= ctr_q;
        end
    end

    always_comb begin
        win_o.older = ctr_d1;
        win_o.bnd   = bnd_q;
        win_o.newer = ctr_q;
    end

    assign rdata_o = ctr_d1;

    // R8: reset clears the centre pipeline
    a_r8_samples_clear: assert property (@(posedge clk)
        rst |=> (ctr_q == 1'b0) && (bnd_q == 1'b0));

endmodule

// File: rtl/bbpd_drive.sv
module bbpd_drive
    import bbpd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cdr_mode_i,
    input  bit_window_t win_i,
    output logic        up_o,
    output logic        dn_o
);

    pd_cmd_e cmd_d;
    pd_cmd_e cmd_q;

    always_comb begin
        cmd_d = cdr_mode_i ? pd_decide(win_i) : PD_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= PD_HOLD;
        else     cmd_q <= cmd_d;
    end

    assign up_o = (cmd_q == PD_RAISE);
    assign dn_o = (cmd_q == PD_LOWER);

    // R2: no transition in the window gives an idle period
    a_r2_hold_flat: assert property (@(posedge clk) disable iff (rst)
        (win_i.older == win_i.newer) |=> (!up_o && !dn_o));

    // R3: boundary matches the older bit -> raise
    a_r3_raise: assert property (@(posedge clk) disable iff (rst)
        (cdr_mode_i && (win_i.older != win_i.newer) && (win_i.bnd == win_i.older))
        |=> (up_o && !dn_o));

    // R4: boundary matches the newer bit -> lower
    a_r4_lower: assert property (@(posedge clk) disable iff (rst)
        (cdr_mode_i && (win_i.older != win_i.newer) && (win_i.bnd == win_i.newer))
        |=> (dn_o && !up_o));

    // R7: acquisition mode keeps the pump idle
    a_r7_gated: assert property (@(posedge clk) disable iff (rst)
        !cdr_mode_i |=> (!up_o && !dn_o));

    // R5: the two requests never overlap
    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({up_o, dn_o}));

endmodule

// File: rtl/bbpd_top.sv
module bbpd_top
    import bbpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sdata_i,
    input  logic cdr_mode_i,
    output logic up_o,
    output logic dn_o,
    output logic rdata_o
);

    bit_window_t win;

    bbpd_sampler u_sampler (
        .clk     (clk),
        .rst     (rst),
        .sdata_i (sdata_i),
        .win_o   (win),
        .rdata_o (rdata_o)
    );

    bbpd_drive u_drive (
        .clk        (clk),
        .rst        (rst),
        .cdr_mode_i (cdr_mode_i),
        .win_i      (win),
        .up_o       (up_o),
        .dn_o       (dn_o)
    );

    // Cycles since reset, saturating, so that history checks stay inside them
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: retimed data is the line value seen two rising edges earlier
    a_r1_retime: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (rdata_o == $past(sdata_i, 2)));

    // R8: first period after reset is idle with cleared data
    a_r8_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!up_o && !dn_o && !rdata_o));

endmodule

// File: tb/bbpd_tb_top.sv
`timescale 1ns/1ps
module bbpd_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sdata = 1'b0;
    logic cdr_mode = 1'b0;
    logic up, dn, rdata;

    always #10 clk = ~clk;   // 50 MHz

    bbpd_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .sdata_i    (sdata),
        .cdr_mode_i (cdr_mode),
        .up_o       (up),
        .dn_o       (dn),
        .rdata_o    (rdata)
    );

    typedef struct {
        int   due;
        logic up;
        logic dn;
        logic rd;
        logic mode;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    logic prev_bit = 1'b0;
    logic last_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, logic [2:0] act, logic [2:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: {up,dn,rdata} actual=%b expected=%b at cycle %0d",
                     req, act, expv, cyc);
        end
    endtask

    // Monitor: pops items as their due period arrives
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                e = q.pop_front();
                if (e.due != cyc) begin
                    n_chk++; n_fail++;
                    $display("FAIL R6: item due %0d missed, actual=%0d expected=%0d", e.due, cyc, e.due);
                end else if (!e.mode)
                    check("R7", {up, dn, rdata}, {e.up, e.dn, e.rd});
                else if (e.up)
                    check("R3", {up, dn, rdata}, {e.up, e.dn, e.rd});
                else if (e.dn)
                    check("R4", {up, dn, rdata}, {e.up, e.dn, e.rd});
                else
                    check("R2", {up, dn, rdata}, {e.up, e.dn, e.rd});
                if (up && dn) begin
                    n_chk++; n_fail++;
                    $display("FAIL R5: up=%b dn=%b expected not both", up, dn);
                end
            end
        end
    end

    // Driver: one bit per period; late=1 moves the edge after the falling clock
    task automatic send_bit(logic b, logic late, logic mode);
        exp_t e;
        @(posedge clk);
        #1;
        cdr_mode = last_mode;
        e.due  = cyc + 2;                       // R6: one edge after the centre sample
        e.mode = mode;
        e.rd   = b;                             // R1
        e.up   = mode && (b != prev_bit) && late;
        e.dn   = mode && (b != prev_bit) && !late;
        q.push_back(e);
        if (late) #12; else #6;
        sdata = b;
        prev_bit = b;
        last_mode = mode;
    endtask

    task automatic flush();
        repeat (4) begin
            @(posedge clk);
            #1;
            cdr_mode = last_mode;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check("R8", {up, dn, rdata}, 3'b000);
        @(posedge clk); #1 rst = 1'b0;

        // alternating bits, edges after the boundary sample -> raise
        for (int i = 0; i < 16; i++) send_bit(i[0], 1'b1, 1'b1);
        // alternating bits, edges before the boundary sample -> lower
        for (int i = 0; i < 16; i++) send_bit(~i[0], 1'b0, 1'b1);
        // flat runs -> hold
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b1, 1'b1);
        // pseudo-random data and offsets
        for (int i = 0; i < 120; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_bit(lfsr[0], lfsr[5], 1'b1);
        end
        // acquisition mode: commands gated, data still retimed
        for (int i = 0; i < 20; i++) send_bit(i[1], i[0], 1'b0);
        for (int i = 0; i < 12; i++) send_bit(i[0], i[2], 1'b1);
        flush();

        // reset in the middle of traffic
        sdata = 1'b1;
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #5;
        check("R8", {up, dn, rdata}, 3'b000);
        sdata = 1'b0;
        prev_bit = 1'b0;
        @(posedge clk); #1 rst = 1'b0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < 10; i++) send_bit(~i[0], 1'b1, 1'b1);
        flush();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule